// File: doc/BRIEF.md
# Windowed Watchdog Timer with Lower, Upper and Warn Limits

This block is a window watchdog that runs on a slow clock. A counter advances once per clock while the watchdog is enabled. Software must service it inside a legal window: a service that comes before the lower limit is too early, and a count that passes the upper limit without a service is too late. A third limit, the warn limit, can raise an interrupt ahead of the deadline. For each limit, software chooses what happens when it is crossed: a reset request, a fault request, an interrupt, or nothing.

All state is reached through a small word-wide register port. The configuration, limit and service registers accept writes only after a two-word key sequence. The interrupt status register is cleared by writing one to it, and a mask register gates the interrupt pin. An auto-service mode turns the upper limit into a plain period: the count restarts there and no action is raised. Two inputs can freeze the count, each under its own configuration bit: one for deep sleep and one for debugger halt.

Register addresses: control 0, lower limit 1, upper limit 2, warn limit 3, service 4, enable status 5, interrupt status 6, interrupt mask 7, lock 8, live count 9. Reads of undefined bits return 0.

Top module: `wdw_watchdog`

## Requirements
- R1: After reset, the control, all three limits, the mask, the interrupt status, the enable status and the lock-open flag (bit 0 of address 8) all read 0, and `irq`, `fault_req` and `reset_req` are low.
- R2: Writes to control, limits and service are dropped unless the lock is open. Writing 16'hA1B2 and then 16'h3C4D to address 8 opens it. Any other write to address 8, including a wrong second word, closes it. The mask and the interrupt status can always be written.
- R3: Control bit 0 enables the watchdog. Counting starts one cycle after the enable is registered, and the live count then rises by one per clock from 0. After a disable, the enable status (bit 0 of address 5) stays 1 for one more cycle. Once the counter has stopped, the count reads 0.
- R4: When the count equals the upper limit and no service is pending, the next increment raises the upper action for one cycle. The action comes from control bits [4:3]: 1 gives `reset_req`, 2 gives `fault_req`, 0 gives nothing.
- R5: A service taken while the count is below the lower limit raises the lower action for one cycle. The action comes from control bits [2:1], with the same encoding as R4. A service taken at a count equal to the lower limit is legal.
- R6: Writing 1 to bit 0 of address 4 sets a service-pending bit. On the next clock the count restarts at 0 and the hardware clears the bit. A pending service takes priority over an upper-limit match in the same cycle.
- R7: If control bit 5 is set, the increment after the count equals the warn limit sets interrupt status bit 0. `irq` is that status ANDed with mask bit 0. Writing 1 to address 6 clears the status.
- R8: With control bit 6 (auto-service) set, reaching the upper limit restarts the count at 0 and raises no action.
- R9: A limit written at clock edge N is first used for comparison at edge N+3.
- R10: With control bit 7 set, the count holds while `deep_sleep` is high. With bit 7 clear, `deep_sleep` has no effect on the count.
- R11: With control bit 8 clear, the count holds while `dbg_halt` is high. With bit 8 set, the count keeps running during a debugger halt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Slow watchdog clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` (combinational) |
| deep_sleep | input | 1 | Selected CPU is in deep sleep |
| dbg_halt | input | 1 | Debugger has halted the system |
| fault_req | output | 1 | One-cycle fault request |
| reset_req | output | 1 | One-cycle reset request |
| irq | output | 1 | Masked warn interrupt |

## Verification
The window check is driven from a table. Each row gives the service point relative to the two limits: well inside the window, below the lower limit, exactly at it, at the upper limit, and one cycle past it. Together the rows separate a legal service, an early service, the priority of service over an upper match, and a late service. Directed runs measure cycle-exact latency for enable, disable, warn and limit updates. Those latencies separate a correct two-stage limit delay from a shorter one. The directed runs also hold the count under the pause inputs with each option both set and clear, and they drive the key sequence with both correct and wrong second words.

// File: rtl/wdw_pkg.sv
`timescale 1ns/1ps
package wdw_pkg;

    typedef enum logic [1:0] {
        ACT_NONE  = 2'd0,
        ACT_RESET = 2'd1,
        ACT_FAULT = 2'd2
    } act_e;

    // Packed MSB first so the struct lines up with control bits [8:0].
    typedef struct packed {
        logic debug_run;
        logic sleep_pause;
        logic auto_svc;
        logic warn_act;
        act_e upper_act;
        act_e lower_act;
        logic enable;
    } cfg_t;

    localparam int CFG_W     = $bits(cfg_t);
    localparam int NUM_LIM   = 3;
    localparam int LIM_LOWER = 0;
    localparam int LIM_UPPER = 1;
    localparam int LIM_WARN  = 2;

    // Limit registers occupy consecutive addresses in LIM_* order.
    localparam int ADR_CTRL  = 0;
    localparam int ADR_LIM0  = 1;
    localparam int ADR_SVC   = 4;
    localparam int ADR_STAT  = 5;
    localparam int ADR_INTR  = 6;
    localparam int ADR_MASK  = 7;
    localparam int ADR_LOCK  = 8;
    localparam int ADR_COUNT = 9;

    typedef enum logic [1:0] {
        LK_CLOSED = 2'd0,
        LK_ARMED  = 2'd1,
        LK_OPEN   = 2'd2
    } lock_e;

endpackage

// File: rtl/wdw_lim_stage.sv
`timescale 1ns/1ps
module wdw_lim_stage #(
    parameter int W     = 16,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lim_in,
    output logic [W-1:0] lim_out
);
    logic [DEPTH-1:0][W-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = lim_in;
        for (int i = 1; i < DEPTH; i++) begin
            pipe_d[i] = pipe_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign lim_out = pipe_q[DEPTH-1];
endmodule

// File: rtl/wdw_regs.sv
`timescale 1ns/1ps
module wdw_regs import wdw_pkg::*; #(
    parameter int               W         = 16,
    parameter int               ADDR_W    = 4,
    parameter int               LIM_DELAY = 2,
    parameter logic [W-1:0]     KEY_FIRST  = 16'hA1B2,
    parameter logic [W-1:0]     KEY_SECOND = 16'h3C4D
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr,
    input  logic [ADDR_W-1:0]           addr,
    input  logic [W-1:0]                wdata,
    output logic [W-1:0]                rdata,
    input  logic [W-1:0]                cnt,
    input  logic                        en_status,
    input  logic                        svc_done,
    input  logic                        warn_hit,
    output cfg_t                        cfg,
    output logic [NUM_LIM-1:0][W-1:0]   lim_act,
    output logic                        svc_pend,
    output logic                        irq
);
    localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(ADR_CTRL);
    localparam logic [ADDR_W-1:0] A_LIM0  = ADDR_W'(ADR_LIM0);
    localparam logic [ADDR_W-1:0] A_SVC   = ADDR_W'(ADR_SVC);
    localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(ADR_STAT);
    localparam logic [ADDR_W-1:0] A_INTR  = ADDR_W'(ADR_INTR);
    localparam logic [ADDR_W-1:0] A_MASK  = ADDR_W'(ADR_MASK);
    localparam logic [ADDR_W-1:0] A_LOCK  = ADDR_W'(ADR_LOCK);
    localparam logic [ADDR_W-1:0] A_COUNT = ADDR_W'(ADR_COUNT);

    typedef struct packed {
        cfg_t                      cfg;
        logic [NUM_LIM-1:0][W-1:0] lim;
        logic                      svc;
        logic                      intr;
        logic                      mask;
        lock_e                     lock;
    } st_t;

    st_t  d, q;
    logic unlocked;
    logic intr_clr;

    assign unlocked = (q.lock == LK_OPEN);
    assign intr_clr = wr && (addr == A_INTR) && wdata[0];

    always_comb begin
        d = q;
        // hardware completion first, so a fresh request in the same cycle wins
        if (svc_done) d.svc = 1'b0;
        d.intr = (q.intr & ~intr_clr) | warn_hit;
        if (wr) begin
            case (addr)
                A_CTRL: if (unlocked) d.cfg = cfg_t'(wdata[CFG_W-1:0]);
                A_SVC:  if (unlocked && wdata[0]) d.svc = 1'b1;
                A_MASK: d.mask = wdata[0];
                A_LOCK: begin
                    if (wdata == KEY_FIRST)                             d.lock = LK_ARMED;
                    else if (q.lock == LK_ARMED && wdata == KEY_SECOND) d.lock = LK_OPEN;
                    else                                                d.lock = LK_CLOSED;
                end
                default: ;
            endcase
            for (int i = 0; i < NUM_LIM; i++) begin
                if (unlocked && addr == A_LIM0 + ADDR_W'(i)) d.lim[i] = wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        rdata = '0;
        case (addr)
            A_CTRL:  rdata[CFG_W-1:0] = q.cfg;
            A_SVC:   rdata[0] = q.svc;
            A_STAT:  rdata[0] = en_status;
            A_INTR:  rdata[0] = q.intr;
            A_MASK:  rdata[0] = q.mask;
            A_LOCK:  rdata[0] = unlocked;
            A_COUNT: rdata = cnt;
            default: ;
        endcase
        for (int i = 0; i < NUM_LIM; i++) begin
            if (addr == A_LIM0 + ADDR_W'(i)) rdata = q.lim[i];
        end
    end

    // Compare values reach the counter through a fixed delay line.
    for (genvar g = 0; g < NUM_LIM; g++) begin : g_lim
        wdw_lim_stage #(.W(W), .DEPTH(LIM_DELAY)) i_stage (
            .clk     (clk),
            .rst_n   (rst_n),
            .lim_in  (q.lim[g]),
            .lim_out (lim_act[g])
        );
    end

    assign cfg      = q.cfg;
    assign svc_pend = q.svc;
    assign irq      = q.intr & q.mask;

    // R2: a write while not unlocked leaves configuration and limits untouched
    assert_locked_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !unlocked && addr != A_LOCK) |=> ($stable(q.cfg) && $stable(q.lim)));

    // R7: a clear with no coincident warn event leaves the status low
    assert_w1c_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (intr_clr && !warn_hit) |=> !q.intr);

    // R6: the pending service bit is taken by the counter one cycle after it is set
    assert_svc_taken_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (q.svc && !(wr && addr == A_SVC)) |=> !q.svc);
endmodule

// File: rtl/wdw_core.sv
`timescale 1ns/1ps
module wdw_core import wdw_pkg::*; #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  cfg_t         cfg,
    input  logic [W-1:0] lower,
    input  logic [W-1:0] upper,
    input  logic [W-1:0] warn,
    input  logic         svc_pend,
    input  logic         deep_sleep,
    input  logic         dbg_halt,
    output logic [W-1:0] cnt,
    output logic         running,
    output logic         svc_done,
    output logic         warn_hit,
    output logic         reset_req,
    output logic         fault_req
);
    typedef struct packed {
        logic [W-1:0] cnt;
        logic         run;
        logic         rst_req;
        logic         flt_req;
    } st_t;

    st_t  d, q;
    logic hold;

    assign hold = (deep_sleep & cfg.sleep_pause) | (dbg_halt & ~cfg.debug_run);

    always_comb begin
        d         = q;
        d.run     = cfg.enable;
        d.rst_req = 1'b0;
        d.flt_req = 1'b0;
        warn_hit  = 1'b0;
        svc_done  = svc_pend;
        if (svc_pend) begin
            d.cnt = '0;
            if (q.run && q.cnt < lower) begin
                d.rst_req = (cfg.lower_act == ACT_RESET);
                d.flt_req = (cfg.lower_act == ACT_FAULT);
            end
        end else if (!q.run) begin
            d.cnt = '0;
        end else if (!hold) begin
            warn_hit = cfg.warn_act && (q.cnt == warn);
            if (q.cnt == upper && cfg.auto_svc) begin
                d.cnt = '0;
            end else begin
                d.cnt = q.cnt + 1'b1;
                if (q.cnt == upper) begin
                    d.rst_req = (cfg.upper_act == ACT_RESET);
                    d.flt_req = (cfg.upper_act == ACT_FAULT);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign cnt       = q.cnt;
    assign running   = q.run;
    assign reset_req = q.rst_req;
    assign fault_req = q.flt_req;

    // R4: the two action outputs never fire together
    assert_one_action_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(reset_req && fault_req));

    // R6: a pending service restarts the count
    assert_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
        svc_pend |=> (q.cnt == '0));

    // R3: a running, unpaused counter away from the upper limit steps by one
    assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (q.run && !hold && !svc_pend && q.cnt != upper) |=> (q.cnt == W'($past(q.cnt) + 1'b1)));

    // R8: auto-service wraps silently at the upper limit
    assert_auto_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (q.run && !hold && !svc_pend && cfg.auto_svc && q.cnt == upper)
        |=> (q.cnt == '0 && !q.rst_req && !q.flt_req));

    // R10: deep sleep freezes the count when the pause option is set
    assert_sleep_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (deep_sleep && cfg.sleep_pause && q.run && !svc_pend) |=> $stable(q.cnt));

    // R11: a debugger halt freezes the count unless run-in-debug is set
    assert_debug_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_halt && !cfg.debug_run && q.run && !svc_pend) |=> $stable(q.cnt));
endmodule

// File: rtl/wdw_watchdog.sv
`timescale 1ns/1ps
module wdw_watchdog import wdw_pkg::*; #(
    parameter int           CNT_W      = 16,
    parameter int           ADDR_W     = 4,
    parameter int           LIM_DELAY  = 2,
    parameter logic [15:0]  KEY_FIRST  = 16'hA1B2,
    parameter logic [15:0]  KEY_SECOND = 16'h3C4D
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [CNT_W-1:0]  reg_wdata,
    output logic [CNT_W-1:0]  reg_rdata,
    input  logic              deep_sleep,
    input  logic              dbg_halt,
    output logic              fault_req,
    output logic              reset_req,
    output logic              irq
);
    cfg_t                          cfg;
    logic [NUM_LIM-1:0][CNT_W-1:0] lim_act;
    logic [CNT_W-1:0]              cnt;
    logic                          running, svc_pend, svc_done, warn_hit, en_status;

    // Enabled status reads 1 until the counter has actually stopped.
    assign en_status = cfg.enable | running;

    wdw_regs #(
        .W          (CNT_W),
        .ADDR_W     (ADDR_W),
        .LIM_DELAY  (LIM_DELAY),
        .KEY_FIRST  (CNT_W'(KEY_FIRST)),
        .KEY_SECOND (CNT_W'(KEY_SECOND))
    ) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (reg_wr),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .rdata     (reg_rdata),
        .cnt       (cnt),
        .en_status (en_status),
        .svc_done  (svc_done),
        .warn_hit  (warn_hit),
        .cfg       (cfg),
        .lim_act   (lim_act),
        .svc_pend  (svc_pend),
        .irq       (irq)
    );

    wdw_core #(.W(CNT_W)) i_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg        (cfg),
        .lower      (lim_act[LIM_LOWER]),
        .upper      (lim_act[LIM_UPPER]),
        .warn       (lim_act[LIM_WARN]),
        .svc_pend   (svc_pend),
        .deep_sleep (deep_sleep),
        .dbg_halt   (dbg_halt),
        .cnt        (cnt),
        .running    (running),
        .svc_done   (svc_done),
        .warn_hit   (warn_hit),
        .reset_req  (reset_req),
        .fault_req  (fault_req)
    );

    // R3: in the cycle the enable drops, the status still reports enabled
    assert_stop_lag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cfg.enable) |-> en_status);
endmodule

// File: tb/test_wdw_watchdog.sv
`timescale 1ns/1ps
module test_wdw_watchdog;
    localparam logic [3:0] A_CTRL = 4'd0, A_LOW = 4'd1, A_UP = 4'd2, A_WARN = 4'd3,
                           A_SVC = 4'd4, A_STAT = 4'd5, A_INTR = 4'd6, A_MASK = 4'd7,
                           A_LOCK = 4'd8, A_CNT = 4'd9;
    localparam logic [15:0] K1 = 16'hA1B2, K2 = 16'h3C4D;

    // lower, upper, cycles before service, expected faults, expected resets
    localparam int NVEC = 7;
    localparam int VEC [NVEC][5] = '{
        '{4, 10,  6, 0, 0},
        '{4, 10,  2, 1, 0},
        '{4, 10,  4, 0, 0},
        '{4, 10,  3, 1, 0},
        '{4, 10, 10, 0, 0},
        '{4, 10, 11, 0, 1},
        '{0,  8,  0, 0, 0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        deep_sleep = 1'b0, dbg_halt = 1'b0;
    logic        fault_req, reset_req, irq;

    int n_tests = 0, n_fail = 0, n_fault = 0, n_reset = 0;

    always #5 clk = ~clk;

    wdw_watchdog i_wdw_watchdog (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .deep_sleep(deep_sleep),
        .dbg_halt(dbg_halt), .fault_req(fault_req), .reset_req(reset_req), .irq(irq)
    );

    always @(negedge clk) begin
        if (fault_req) n_fault++;
        if (reset_req) n_reset++;
    end

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] v);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] v, c1, c2;
        int f0, r0, mx;

        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        rd(A_CTRL, v); check("R1 ctrl", v, 0);
        rd(A_LOW, v);  check("R1 lower", v, 0);
        rd(A_UP, v);   check("R1 upper", v, 0);
        rd(A_WARN, v); check("R1 warn", v, 0);
        rd(A_MASK, v); check("R1 mask", v, 0);
        rd(A_STAT, v); check("R1 status", v, 0);
        rd(A_LOCK, v); check("R1 lock", v, 0);
        check("R1 outputs", {irq, fault_req, reset_req}, 0);

        // R2 lock
        wr(A_LOW, 16'd5); rd(A_LOW, v); check("R2 locked write", v, 0);
        wr(A_LOCK, K1); wr(A_LOCK, 16'h1234);
        wr(A_LOW, 16'd5); rd(A_LOW, v); check("R2 wrong key", v, 0);
        wr(A_LOCK, K1); wr(A_LOCK, K2);
        rd(A_LOCK, v); check("R2 open flag", v, 1);
        wr(A_LOW, 16'd5); rd(A_LOW, v); check("R2 open write", v, 5);

        // R4 R5 R6 window table
        for (int i = 0; i < NVEC; i++) begin
            wr(A_CTRL, 16'd0);
            wr(A_LOW, 16'(VEC[i][0]));
            wr(A_UP, 16'(VEC[i][1]));
            idle(3);
            f0 = n_fault; r0 = n_reset;
            wr(A_CTRL, 16'd13);
            idle(VEC[i][2]);
            wr(A_SVC, 16'd1);
            idle(4);
            check($sformatf("R5 early-service fault, row %0d", i), n_fault - f0, VEC[i][3]);
            check($sformatf("R4 R6 late reset, row %0d", i), n_reset - r0, VEC[i][4]);
        end

        // R3 enable, count, disable lag
        wr(A_CTRL, 16'd0);
        wr(A_LOW, 16'd0); wr(A_UP, 16'd1000);
        idle(3);
        wr(A_CTRL, 16'd1);
        rd(A_STAT, v); check("R3 status on enable", v, 1);
        rd(A_CNT, v);  check("R3 count at start", v, 0);
        idle(5);
        rd(A_CNT, v);  check("R3 count after 5", v, 4);
        wr(A_CTRL, 16'd0);
        rd(A_STAT, v); check("R3 status lag", v, 1);
        idle(1);
        rd(A_STAT, v); check("R3 status stopped", v, 0);
        idle(1);
        rd(A_CNT, v);  check("R3 count cleared", v, 0);

        // R6 service bit self-clears, count restarts
        wr(A_CTRL, 16'd1);
        idle(6);
        wr(A_SVC, 16'd1);
        rd(A_SVC, v); check("R6 pending set", v, 1);
        idle(1);
        rd(A_SVC, v); check("R6 pending cleared", v, 0);
        rd(A_CNT, v); check("R6 count restarted", v, 0);

        // R9 limit latency
        wr(A_CTRL, 16'd9);
        idle(3);
        rd(A_CNT, c1);
        r0 = n_reset;
        wr(A_UP, c1 + 16'd2);
        idle(6);
        check("R9 limit not yet active", n_reset - r0, 0);
        rd(A_CNT, c1);
        r0 = n_reset;
        wr(A_UP, c1 + 16'd3);
        idle(6);
        check("R9 limit active at third edge", n_reset - r0, 1);

        // R8 auto-service
        wr(A_CTRL, 16'd0);
        wr(A_UP, 16'd5);
        idle(3);
        r0 = n_reset; mx = 0;
        wr(A_CTRL, 16'd73);
        for (int k = 0; k < 30; k++) begin
            @(negedge clk);
            rd(A_CNT, v);
            if (int'(v) > mx) mx = int'(v);
        end
        check("R8 count peak", mx, 5);
        check("R8 no action", n_reset - r0, 0);

        // R7 warn interrupt
        wr(A_CTRL, 16'd0);
        wr(A_UP, 16'd1000); wr(A_WARN, 16'd3);
        wr(A_MASK, 16'd1); wr(A_INTR, 16'd1);
        idle(3);
        wr(A_CTRL, 16'd33);
        idle(4);
        check("R7 irq before warn", irq, 0);
        idle(1);
        check("R7 irq at warn", irq, 1);
        wr(A_INTR, 16'd1);
        check("R7 irq after clear", irq, 0);
        rd(A_INTR, v); check("R7 status after clear", v, 0);
        wr(A_CTRL, 16'd0); wr(A_MASK, 16'd0);
        idle(2);
        wr(A_CTRL, 16'd33);
        idle(8);
        check("R7 masked irq", irq, 0);
        rd(A_INTR, v); check("R7 masked status", v, 1);
        wr(A_CTRL, 16'd0); wr(A_INTR, 16'd1);
        idle(2);
        wr(A_CTRL, 16'd1);
        idle(8);
        rd(A_INTR, v); check("R7 warn action none", v, 0);

        // R10 deep-sleep pause
        wr(A_CTRL, 16'd129);
        idle(4);
        deep_sleep = 1'b1;
        rd(A_CNT, c1); idle(5); rd(A_CNT, c2);
        check("R10 held in sleep", c2, c1);
        wr(A_CTRL, 16'd1);
        rd(A_CNT, c1); idle(5); rd(A_CNT, c2);
        check("R10 sleep ignored when option clear", c2, c1 + 16'd5);
        deep_sleep = 1'b0;

        // R11 debug halt
        dbg_halt = 1'b1;
        rd(A_CNT, c1); idle(5); rd(A_CNT, c2);
        check("R11 held in debug halt", c2, c1);
        wr(A_CTRL, 16'd257);
        rd(A_CNT, c1); idle(5); rd(A_CNT, c2);
        check("R11 runs with debug-run", c2, c1 + 16'd5);
        dbg_halt = 1'b0;

        // R2 relock
        wr(A_LOCK, 16'd0);
        rd(A_LOCK, v); check("R2 relock flag", v, 0);
        wr(A_UP, 16'd77);
        rd(A_UP, v); check("R2 relocked write dropped", v, 1000);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule